// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Arbiter

This block sits in front of one processor's interrupt inputs. It watches a small window of interrupt sources, each carrying an enable bit, a pending bit, a group bit, a per-CPU target mask and an 8-bit priority. From these it finds the most urgent eligible source and publishes that source's ID as the highest-pending interrupt. It also decides whether to assert the processor's normal interrupt line or its fast interrupt line.

Sources in the window have consecutive IDs starting at a parameterised first ID. IDs below a parameterised private limit belong to this CPU alone and ignore the target mask. The block is gated by two group enables at the distributor level and two at the CPU interface. It also takes a priority mask, a running priority and a fast-interrupt enable. The arbitration result is registered, so it appears one clock after its inputs change.

Top module: `irq_arbiter`

## Requirements
- R1: When neither distributor group enable is set, or neither CPU-interface group enable is set, both lines are low and the published ID is 1023.
- R2: A source takes part in arbitration only while both its enable bit and its pending bit are 1.
- R3: A source whose ID is at or above the private limit (32) takes part only if bit CPU_IDX of its target mask is 1. A source below that limit ignores its target mask.
- R4: Among eligible sources, the one with the numerically smallest priority value wins.
- R5: When several eligible sources share the smallest priority value, the lowest ID wins.
- R6: The winner's ID is published only when its priority is strictly below the priority mask. Otherwise the ID is 1023 and both lines are low.
- R7: A line is raised only when the winner's priority is also strictly below the 9-bit running priority. A winner that is published but not below the running priority leaves both lines low.
- R8: A line is raised only when the winner's group (group bit 0 = group 0, 1 = group 1) has its enable bit set at both the distributor and the CPU interface. Enable bit index equals the group number.
- R9: A qualifying group-0 winner raises the fast line when the CPU fast-interrupt enable is 1. Every other qualifying winner raises the normal line. The two lines are never high together.
- R10: A running priority of 0x100 means idle, so a winner with priority 0xFE under a mask of 0xFF raises a line.
- R11: Outputs are registered. They reflect the inputs present at the previous rising clock edge and do not change between edges.
- R12: During and immediately after reset, the published ID is 1023 and both lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_enable | input | NUM_SRC | Per-source enable |
| src_pending | input | NUM_SRC | Per-source pending flag for this CPU |
| src_group | input | NUM_SRC | Per-source group (0 or 1) |
| src_targets | input | NUM_SRC*NCPU | Per-source CPU target masks, source i at [i*NCPU +: NCPU] |
| src_prio | input | NUM_SRC*8 | Per-source priority, source i at [i*8 +: 8] |
| dist_grp_en | input | 2 | Distributor enable, bit g for group g |
| cpu_grp_en | input | 2 | CPU-interface enable, bit g for group g |
| cpu_fiq_en | input | 1 | Route group-0 winners to the fast line |
| prio_mask | input | 8 | Priority mask |
| run_prio | input | 9 | Running priority, 0x100 when idle |
| hp_id | output | 10 | Highest-pending ID, 1023 when none |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
The hardest case to reach from the ports is a winner that is published but must not raise a line. This needs a priority that passes the mask but not the running priority, or a group enabled at one level but not the other. The stimulus table sets the priority equal to the mask and to the running priority, and one step below each. It then flips the group enables one level at a time while the pending set stays fixed. Equal-priority ties across the private/shared ID boundary are also placed in the table.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 8;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0] NO_IRQ_ID = 10'd1023;

  typedef struct packed {
    logic              found;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
    logic              grp;
  } winner_t;
endpackage

// File: rtl/src_qualify.sv
module src_qualify #(
  parameter int NUM_SRC    = 8,
  parameter int NCPU       = 4,
  parameter int CPU_IDX    = 1,
  parameter int FIRST_ID   = 28,
  parameter int PRIV_LIMIT = 32
) (
  input  logic [NUM_SRC-1:0]      en,
  input  logic [NUM_SRC-1:0]      pend,
  input  logic [NUM_SRC*NCPU-1:0] targets,
  output logic [NUM_SRC-1:0]      elig
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam bit IS_PRIV = (FIRST_ID + i) < PRIV_LIMIT;
    if (IS_PRIV) begin : g_priv
      assign elig[i] = en[i] & pend[i];
    end else begin : g_shared
      assign elig[i] = en[i] & pend[i] & targets[i*NCPU + CPU_IDX];
    end
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int FIRST_ID = 28
) (
  input  logic [NUM_SRC-1:0]        elig,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [NUM_SRC-1:0]        grp,
  output winner_t                   win
);
  always_comb begin
    win = '0;
    win.id = NO_IRQ_ID;
    for (int i = 0; i < NUM_SRC; i++) begin
      // strict compare keeps the earlier (lower) ID on a tie
      if (elig[i] && (!win.found || prio[i*PRIO_W +: PRIO_W] < win.prio)) begin
        win.found = 1'b1;
        win.prio  = prio[i*PRIO_W +: PRIO_W];
        win.id    = ID_W'(FIRST_ID + i);
        win.grp   = grp[i];
      end
    end
  end
endmodule

// File: rtl/line_gate.sv
module line_gate
  import irq_arb_pkg::*;
(
  input  winner_t           win,
  input  logic [1:0]        dist_grp_en,
  input  logic [1:0]        cpu_grp_en,
  input  logic              cpu_fiq_en,
  input  logic [PRIO_W-1:0] prio_mask,
  input  logic [PRIO_W:0]   run_prio,
  output logic [ID_W-1:0]   hp_d,
  output logic              irq_d,
  output logic              fiq_d
);
  logic any_on, unmasked, preempts, grp_ok;

  always_comb begin
    any_on   = (|dist_grp_en) && (|cpu_grp_en);
    unmasked = win.found && (win.prio < prio_mask);
    preempts = {1'b0, win.prio} < run_prio;
    grp_ok   = dist_grp_en[win.grp] && cpu_grp_en[win.grp];
    hp_d  = NO_IRQ_ID;
    irq_d = 1'b0;
    fiq_d = 1'b0;
    if (any_on && unmasked) begin
      hp_d = win.id;
      if (preempts && grp_ok) begin
        if (!win.grp && cpu_fiq_en) fiq_d = 1'b1;
        else                        irq_d = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int NCPU       = 4,
  parameter int CPU_IDX    = 1,
  parameter int FIRST_ID   = 28,
  parameter int PRIV_LIMIT = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          src_enable,
  input  logic [NUM_SRC-1:0]          src_pending,
  input  logic [NUM_SRC-1:0]          src_group,
  input  logic [NUM_SRC*NCPU-1:0]     src_targets,
  input  logic [NUM_SRC*PRIO_W-1:0]   src_prio,
  input  logic [1:0]                  dist_grp_en,
  input  logic [1:0]                  cpu_grp_en,
  input  logic                        cpu_fiq_en,
  input  logic [PRIO_W-1:0]           prio_mask,
  input  logic [PRIO_W:0]             run_prio,
  output logic [ID_W-1:0]             hp_id,
  output logic                        irq_o,
  output logic                        fiq_o
);
  logic [NUM_SRC-1:0] elig;
  winner_t            win;
  logic [ID_W-1:0]    hp_d, hp_q;
  logic               irq_d, irq_q, fiq_d, fiq_q;
  logic               upd_en;

  src_qualify #(.NUM_SRC(NUM_SRC), .NCPU(NCPU), .CPU_IDX(CPU_IDX),
                .FIRST_ID(FIRST_ID), .PRIV_LIMIT(PRIV_LIMIT)) u_qual (
    .en(src_enable), .pend(src_pending), .targets(src_targets), .elig(elig));

  prio_pick #(.NUM_SRC(NUM_SRC), .FIRST_ID(FIRST_ID)) u_pick (
    .elig(elig), .prio(src_prio), .grp(src_group), .win(win));

  line_gate u_gate (
    .win(win), .dist_grp_en(dist_grp_en), .cpu_grp_en(cpu_grp_en),
    .cpu_fiq_en(cpu_fiq_en), .prio_mask(prio_mask), .run_prio(run_prio),
    .hp_d(hp_d), .irq_d(irq_d), .fiq_d(fiq_d));

  assign upd_en = (hp_d != hp_q) || (irq_d != irq_q) || (fiq_d != fiq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_q  <= NO_IRQ_ID;
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else if (upd_en) begin
      hp_q  <= hp_d;
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  assign hp_id = hp_q;
  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  // R9
  lines_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_q, fiq_q}));
  // R1
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|dist_grp_en) || !(|cpu_grp_en)) |=> (hp_q == NO_IRQ_ID && !irq_q && !fiq_q));
  // R6
  line_has_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q || fiq_q) |-> (hp_q != NO_IRQ_ID));
  // R9
  fiq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_q) |-> $past(cpu_fiq_en));
  // R7
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ({1'b0, $past(win.prio)} < $past(run_prio)));
endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  localparam int NS = 8;
  localparam int NC = 4;
  localparam int CI = 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   en = '0, pend = '0, grp = '0;
  logic [NS*NC-1:0] tgt = '0;
  logic [NS*8-1:0] pr = '0;
  logic [1:0]      dg = '0, cg = '0;
  logic            fq = 1'b0;
  logic [7:0]      mk = '0;
  logic [8:0]      rp = 9'h100;
  logic [9:0]      hp_id;
  logic            irq_o, fiq_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_arbiter dut (
    .clk(clk), .rst_n(rst_n), .src_enable(en), .src_pending(pend),
    .src_group(grp), .src_targets(tgt), .src_prio(pr),
    .dist_grp_en(dg), .cpu_grp_en(cg), .cpu_fiq_en(fq),
    .prio_mask(mk), .run_prio(rp), .hp_id(hp_id), .irq_o(irq_o), .fiq_o(fiq_o));

  typedef struct packed {
    logic [7:0]  en, pend, grp, tthis;
    logic [63:0] pr;
    logic [1:0]  dg, cg;
    logic        fq;
    logic [7:0]  mk;
    logic [8:0]  rp;
    logic [9:0]  xid;
    logic        xirq, xfiq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    // R2: single pending shared source ID 33
    '{8'hFF, 8'h20, 8'hFF, 8'hFF, {8{8'h40}}, 2'b11, 2'b11, 1'b0, 8'hFF, 9'h100, 10'd33, 1'b1, 1'b0},
    // R2: same source disabled
    '{8'hDF, 8'h20, 8'hFF, 8'hFF, {8{8'h40}}, 2'b11, 2'b11, 1'b0, 8'hFF, 9'h100, 10'd1023, 1'b0, 1'b0},
    // R3: shared sources aimed at another CPU only
    '{8'hFF, 8'hF0, 8'hFF, 8'h0F, {8{8'h40}}, 2'b11, 2'b11, 1'b0, 8'hFF, 9'h100, 10'd1023, 1'b0, 1'b0},
    // R3: private ID 28 ignores its target mask, shared ID 32 filtered
    '{8'hFF, 8'h11, 8'hFF, 8'h00, {8{8'h40}}, 2'b11, 2'b11, 1'b0, 8'hFF, 9'h100, 10'd28, 1'b1, 1'b0},
    // R4: lowest value 0x10 at ID 34
    '{8'hFF, 8'hFF, 8'hFF, 8'hFF, {8'h20,8'h10,8'h30,8'h50,8'h50,8'h60,8'h70,8'h90}, 2'b11, 2'b11, 1'b0, 8'hFF, 9'h100, 10'd34, 1'b1, 1'b0},
    // R5: tie among IDs 30,33,35 keeps 30
    '{8'hFF, 8'hA4, 8'hFF, 8'hFF, {8{8'h40}}, 2'b11, 2'b11, 1'b0, 8'hFF, 9'h100, 10'd30, 1'b1, 1'b0},
    // R5: tie across private/shared boundary IDs 31,32 keeps 31
    '{8'hFF, 8'h18, 8'hFF, 8'hFF, {8{8'h40}}, 2'b11, 2'b11, 1'b0, 8'hFF, 9'h100, 10'd31, 1'b1, 1'b0},
    // R6: priority equal to mask is masked
    '{8'hFF, 8'h08, 8'hFF, 8'hFF, {8{8'h80}}, 2'b11, 2'b11, 1'b0, 8'h80, 9'h100, 10'd1023, 1'b0, 1'b0},
    // R6: one above priority passes
    '{8'hFF, 8'h08, 8'hFF, 8'hFF, {8{8'h80}}, 2'b11, 2'b11, 1'b0, 8'h81, 9'h100, 10'd31, 1'b1, 1'b0},
    // R7: priority equal to running priority: published, no line
    '{8'hFF, 8'h08, 8'hFF, 8'hFF, {8{8'h80}}, 2'b11, 2'b11, 1'b0, 8'hFF, 9'h080, 10'd31, 1'b0, 1'b0},
    // R7: running priority one higher raises line
    '{8'hFF, 8'h08, 8'hFF, 8'hFF, {8{8'h80}}, 2'b11, 2'b11, 1'b0, 8'hFF, 9'h081, 10'd31, 1'b1, 1'b0},
    // R8: group 1 winner, distributor only group 0 on
    '{8'hFF, 8'h08, 8'hFF, 8'hFF, {8{8'h40}}, 2'b01, 2'b11, 1'b0, 8'hFF, 9'h100, 10'd31, 1'b0, 1'b0},
    // R8: group 1 winner, CPU interface only group 0 on
    '{8'hFF, 8'h08, 8'hFF, 8'hFF, {8{8'h40}}, 2'b11, 2'b01, 1'b0, 8'hFF, 9'h100, 10'd31, 1'b0, 1'b0},
    // R9: group 0 winner, fast enable on -> fast line
    '{8'hFF, 8'h08, 8'h00, 8'hFF, {8{8'h40}}, 2'b11, 2'b11, 1'b1, 8'hFF, 9'h100, 10'd31, 1'b0, 1'b1},
    // R9: group 0 winner, fast enable off -> normal line
    '{8'hFF, 8'h08, 8'h00, 8'hFF, {8{8'h40}}, 2'b11, 2'b11, 1'b0, 8'hFF, 9'h100, 10'd31, 1'b1, 1'b0},
    // R9: group 1 winner with fast enable on -> normal line
    '{8'hFF, 8'h08, 8'hFF, 8'hFF, {8{8'h40}}, 2'b11, 2'b11, 1'b1, 8'hFF, 9'h100, 10'd31, 1'b1, 1'b0},
    // R1: distributor groups off
    '{8'hFF, 8'h08, 8'hFF, 8'hFF, {8{8'h40}}, 2'b00, 2'b11, 1'b0, 8'hFF, 9'h100, 10'd1023, 1'b0, 1'b0},
    // R1: CPU interface groups off
    '{8'hFF, 8'h08, 8'h00, 8'hFF, {8{8'h40}}, 2'b11, 2'b00, 1'b1, 8'hFF, 9'h100, 10'd1023, 1'b0, 1'b0},
    // R10: priority 0xFE, mask 0xFF, idle running priority
    '{8'hFF, 8'h80, 8'hFF, 8'hFF, {8{8'hFE}}, 2'b11, 2'b11, 1'b0, 8'hFF, 9'h100, 10'd35, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [9:0] gid, input logic [9:0] xid,
                     input logic gi, input logic xi, input logic gf, input logic xf);
    total++;
    if (gid !== xid || gi !== xi || gf !== xf) begin
      bad++;
      $display("FAIL %s: got id=%0d irq=%b fiq=%b expected id=%0d irq=%b fiq=%b",
               tag, gid, gi, gf, xid, xi, xf);
    end
  endtask

  task automatic apply(input vec_t v);
    en = v.en; pend = v.pend; grp = v.grp; pr = v.pr;
    dg = v.dg; cg = v.cg; fq = v.fq; mk = v.mk; rp = v.rp;
    for (int i = 0; i < NS; i++)
      tgt[i*NC +: NC] = v.tthis[i] ? 4'b0010 : 4'b0100;
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state while held
    chk("R12 in reset", hp_id, 10'd1023, irq_o, 1'b0, fiq_o, 1'b0);
    apply(VT[0]);
    @(negedge clk);
    chk("R12 in reset with pending", hp_id, 10'd1023, irq_o, 1'b0, fiq_o, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      apply(VT[k]);
      @(posedge clk); @(negedge clk);
      chk($sformatf("vector %0d", k), hp_id, VT[k].xid, irq_o, VT[k].xirq, fiq_o, VT[k].xfiq);
    end

    // R11: output holds until the next edge after an input change
    apply(VT[0]);
    @(posedge clk); @(negedge clk);
    apply(VT[1]);
    #1;
    chk("R11 before edge", hp_id, 10'd33, irq_o, 1'b1, fiq_o, 1'b0);
    @(posedge clk); #1;
    chk("R11 after edge", hp_id, 10'd1023, irq_o, 1'b0, fiq_o, 1'b0);

    // R12: asynchronous reset mid-run
    @(negedge clk);
    apply(VT[13]);
    @(posedge clk); @(negedge clk);
    chk("R9 fast before reset", hp_id, 10'd31, irq_o, 1'b0, fiq_o, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R12 async reset", hp_id, 10'd1023, irq_o, 1'b0, fiq_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R12 recovery", hp_id, 10'd31, irq_o, 1'b0, fiq_o, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule